// File: doc/BRIEF.md
# Selected-Bus Transmitter Shutdown Controller

This block is the mode-code handler that a dual-redundant MIL-STD-1553 remote terminal uses to shut down the transmitter of one of its two buses on command. It sits after the word decoder. For each received command it takes one strobe carrying several items: the decoded command fields, the bus that carried the command, the accompanying mode data word, and the validity and broadcast flags. It then decides how the terminal answers. The answer covers the message-error and broadcast-received status bits, whether a status word goes out, and whether the host is interrupted.

With automatic handling enabled, the data word of the shutdown mode code is compared with the select value of the bus that did not carry the command. On a match, that bus is shut down. Depending on configuration, either its transmitter alone or its transmitter and receiver are inhibited. The shutdown is latched and reported in two built-in-test flags. It is applied through internal inhibit bits or through external per-bus inhibit outputs. Only the override mode codes, the reset-terminal mode code, a software reset or a hardware reset release it. With automatic handling disabled, the block only interrupts the host. In either case the data word is handed to storage after the status word has gone out, and every store flips a ping-pong buffer select.

Top module: `xsd_shutdown_ctrl`

## Requirements
- R1: After reset is asserted, every output is 0: response strobe, status bits, interrupt, store strobe, buffer select, stored word, shutdown flags and both inhibit outputs.
- R2: A valid, non-broadcast mode command with code 20 (cmd_mc=1, cmd_code=5'b10100) and cmd_tr=0 makes rsp_send pulse for one cycle and clears stat_me and stat_bcr. All of these are visible in the cycle after the strobe.
- R3: The same command sent as broadcast clears stat_me, sets stat_bcr and produces no rsp_send pulse.
- R4: Code 20 with cmd_tr=1 and cfg_undef_invalid=0 is ignored. It causes no response, no status change, no interrupt, no store and no shutdown.
- R5: Code 20 with cmd_tr=1 and cfg_undef_invalid=1 is treated as illegal. It sets stat_me, sets stat_bcr to the broadcast flag, and pulses rsp_send unless the command is broadcast. It produces no store.
- R6: With cfg_auto=1, an accepted code-20 command on bus b (0 = A, 1 = B) is compared with the select value of bus 1-b. On equality, tx_sd_flag[1-b] is set. rx_sd_flag[1-b] is set as well when cfg_txrx=1. A mismatch changes no flag.
- R7: The latched transmitter shutdown appears on inh_pin when cfg_pin_mode=1 and on inh_bit when cfg_pin_mode=0. The unused output stays 0.
- R8: With cfg_auto=0, an accepted code-20 command pulses irq for one cycle and shuts nothing down.
- R9: The data word of an accepted code-20 command is stored one cycle after the next stat_done pulse. When no status word is sent (broadcast, or the command bus transmitter is shut down), it is stored two cycles after the strobe. Each store pulses store_stb, toggles store_sel and presents the word on store_word.
- R10: A command on a bus whose transmitter is shut down is still obeyed, but rsp_send stays 0. A command on a bus whose receiver is shut down is ignored completely.
- R11: A valid mode command with code 5, 8 or 21, or a sw_reset pulse, clears the shutdown latches of both buses in the next cycle. Other mode codes leave the latches unchanged.
- R12: A strobe with cmd_valid=0 has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| cmd_stb | input | 1 | One-cycle strobe for a decoded command and its data word |
| cmd_valid | input | 1 | Command word was received valid |
| cmd_mc | input | 1 | Command is a mode command |
| cmd_tr | input | 1 | Transmit/receive bit of the command |
| cmd_bus | input | 1 | Bus that carried the command (0 = A, 1 = B) |
| cmd_bcast | input | 1 | Command was addressed as broadcast |
| cmd_code | input | CODE_W | Mode code field |
| cmd_data | input | DATA_W | Mode data word received with the command |
| sel_a | input | DATA_W | Select value of bus A |
| sel_b | input | DATA_W | Select value of bus B |
| stat_done | input | 1 | Status word transmission finished |
| sw_reset | input | 1 | Software reset pulse |
| cfg_auto | input | 1 | 1 = compare and shut down automatically, 0 = interrupt host only |
| cfg_txrx | input | 1 | 1 = inhibit transmitter and receiver, 0 = transmitter only |
| cfg_undef_invalid | input | 1 | 1 = treat code 20 with T/R=1 as illegal |
| cfg_pin_mode | input | 1 | 1 = apply shutdown on inh_pin, 0 = on inh_bit |
| rsp_send | output | 1 | Pulse: transmit status word |
| stat_me | output | 1 | Message error status bit |
| stat_bcr | output | 1 | Broadcast command received status bit |
| irq | output | 1 | Pulse: host alert for a code-20 command |
| store_stb | output | 1 | Pulse: store store_word to the selected buffer |
| store_sel | output | 1 | Ping-pong buffer select |
| store_word | output | DATA_W | Data word to store |
| tx_sd_flag | output | 2 | Built-in-test transmitter shutdown flags, bit 0 = A |
| rx_sd_flag | output | 2 | Built-in-test receiver shutdown flags, bit 0 = A |
| inh_bit | output | 2 | Internal transmitter inhibit bits |
| inh_pin | output | 2 | External transmitter inhibit outputs |

## Verification
The bench builds the block with DATA_W=4, with select values 5 for bus A and 10 for bus B. This shrinks the data space, so every one of the 16 data words can be swept on both buses under all eight combinations of automatic mode, shutdown depth and inhibit routing. Matches and near misses against both select values are therefore covered exhaustively. Directed sequences cover the remaining cases: broadcast, the two undefined-direction treatments, transmit-blocked and receive-blocked buses, each release path, and invalid strobes.

// File: rtl/xsd_pkg.sv
package xsd_pkg;
  localparam int CODE_W = 5;
  localparam logic [CODE_W-1:0] MC_SEL_SHUT  = 5'd20;
  localparam logic [CODE_W-1:0] MC_OVR_LO    = 5'd5;
  localparam logic [CODE_W-1:0] MC_OVR_HI    = 5'd21;
  localparam logic [CODE_W-1:0] MC_RT_RESET  = 5'd8;
  localparam int NBUS = 2;

  typedef enum logic [1:0] {
    ACT_NONE    = 2'd0,
    ACT_SHUT    = 2'd1,
    ACT_ILLEGAL = 2'd2,
    ACT_REACT   = 2'd3
  } act_e;
endpackage

// File: rtl/xsd_rst_sync.sv
module xsd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/xsd_decode.sv
module xsd_decode
  import xsd_pkg::*;
(
  input  logic                     cmd_stb,
  input  logic                     cmd_valid,
  input  logic                     cmd_mc,
  input  logic                     cmd_tr,
  input  logic                     cmd_bus,
  input  logic [CODE_W-1:0]        cmd_code,
  input  logic [NBUS-1:0]          rx_shut,
  input  logic                     cfg_undef_invalid,
  output act_e                     act
);
  logic heard;
  logic react_code;

  assign heard      = cmd_stb & cmd_valid & cmd_mc & ~rx_shut[cmd_bus];
  assign react_code = (cmd_code == MC_OVR_LO) | (cmd_code == MC_OVR_HI) |
                      (cmd_code == MC_RT_RESET);

  always_comb begin
    act = ACT_NONE;
    if (heard) begin
      if (cmd_code == MC_SEL_SHUT) begin
        if (!cmd_tr)                act = ACT_SHUT;
        else if (cfg_undef_invalid) act = ACT_ILLEGAL;
        else                        act = ACT_NONE;
      end else if (react_code) begin
        act = ACT_REACT;
      end
    end
  end
endmodule

// File: rtl/xsd_bus_latch.sv
module xsd_bus_latch (
  input  logic clk,
  input  logic rst_sn,
  input  logic set_tx,
  input  logic set_rx,
  input  logic clr,
  output logic tx_q,
  output logic rx_q
);
  logic tx_d, rx_d;

  always_comb begin
    tx_d = tx_q;
    rx_d = rx_q;
    if (clr) begin
      tx_d = 1'b0;
      rx_d = 1'b0;
    end else begin
      if (set_tx) tx_d = 1'b1;
      if (set_rx) rx_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      tx_q <= 1'b0;
      rx_q <= 1'b0;
    end else begin
      tx_q <= tx_d;
      rx_q <= rx_d;
    end
  end

  p_tx_set_source_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(tx_q) |-> $past(set_tx));
  p_rx_needs_tx_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    rx_q |-> tx_q);
  p_release_r11: assert property (@(posedge clk) disable iff (!rst_sn)
    $past(clr) |-> (!tx_q && !rx_q));
endmodule

// File: rtl/xsd_store_seq.sv
module xsd_store_seq #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              soft_clr,
  input  logic              accept,
  input  logic              no_status,
  input  logic [DATA_W-1:0] data_in,
  input  logic              stat_done,
  output logic              store_stb,
  output logic              store_sel,
  output logic [DATA_W-1:0] store_word
);
  logic              pend_q, pend_d;
  logic              wait_q, wait_d;
  logic [DATA_W-1:0] hold_q, hold_d;
  logic              stb_d, sel_d;
  logic [DATA_W-1:0] word_d;
  logic              fire;

  assign fire = pend_q & (~wait_q | stat_done);

  always_comb begin
    pend_d = pend_q;
    wait_d = wait_q;
    hold_d = hold_q;
    stb_d  = 1'b0;
    sel_d  = store_sel;
    word_d = store_word;
    if (soft_clr) begin
      pend_d = 1'b0;
      wait_d = 1'b0;
      sel_d  = 1'b0;
    end else begin
      if (fire) begin
        pend_d = 1'b0;
        stb_d  = 1'b1;
        sel_d  = ~store_sel;
        word_d = hold_q;
      end
      if (accept) begin
        pend_d = 1'b1;
        wait_d = ~no_status;
        hold_d = data_in;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      pend_q     <= 1'b0;
      wait_q     <= 1'b0;
      hold_q     <= '0;
      store_stb  <= 1'b0;
      store_sel  <= 1'b0;
      store_word <= '0;
    end else begin
      pend_q     <= pend_d;
      wait_q     <= wait_d;
      hold_q     <= hold_d;
      store_stb  <= stb_d;
      store_sel  <= sel_d;
      store_word <= word_d;
    end
  end

  p_store_pending_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    store_stb |-> $past(pend_q));
  p_store_flips_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    store_stb |-> (store_sel != $past(store_sel)));
endmodule

// File: rtl/xsd_shutdown_ctrl.sv
module xsd_shutdown_ctrl
  import xsd_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_stb,
  input  logic                cmd_valid,
  input  logic                cmd_mc,
  input  logic                cmd_tr,
  input  logic                cmd_bus,
  input  logic                cmd_bcast,
  input  logic [CODE_W-1:0]   cmd_code,
  input  logic [DATA_W-1:0]   cmd_data,
  input  logic [DATA_W-1:0]   sel_a,
  input  logic [DATA_W-1:0]   sel_b,
  input  logic                stat_done,
  input  logic                sw_reset,
  input  logic                cfg_auto,
  input  logic                cfg_txrx,
  input  logic                cfg_undef_invalid,
  input  logic                cfg_pin_mode,
  output logic                rsp_send,
  output logic                stat_me,
  output logic                stat_bcr,
  output logic                irq,
  output logic                store_stb,
  output logic                store_sel,
  output logic [DATA_W-1:0]   store_word,
  output logic [NBUS-1:0]     tx_sd_flag,
  output logic [NBUS-1:0]     rx_sd_flag,
  output logic [NBUS-1:0]     inh_bit,
  output logic [NBUS-1:0]     inh_pin
);
  logic              rst_sn;
  act_e              act;
  logic [DATA_W-1:0] sel_other;
  logic              other_bus;
  logic              hit;
  logic              tx_blocked;
  logic              answer;
  logic              release_all;
  logic              send_d, me_d, bcr_d, irq_d;

  xsd_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  xsd_decode u_dec (
    .cmd_stb           (cmd_stb),
    .cmd_valid         (cmd_valid),
    .cmd_mc            (cmd_mc),
    .cmd_tr            (cmd_tr),
    .cmd_bus           (cmd_bus),
    .cmd_code          (cmd_code),
    .rx_shut           (rx_sd_flag),
    .cfg_undef_invalid (cfg_undef_invalid),
    .act               (act)
  );

  assign other_bus   = ~cmd_bus;
  assign sel_other   = cmd_bus ? sel_a : sel_b;
  assign hit         = (act == ACT_SHUT) & cfg_auto & (cmd_data == sel_other);
  assign tx_blocked  = tx_sd_flag[cmd_bus];
  assign answer      = (act == ACT_SHUT) | (act == ACT_ILLEGAL);
  assign release_all = (act == ACT_REACT) | sw_reset;

  for (genvar b = 0; b < NBUS; b++) begin : g_bus
    logic aim;
    assign aim = hit & (other_bus == b[0]);

    xsd_bus_latch u_latch (
      .clk    (clk),
      .rst_sn (rst_sn),
      .set_tx (aim),
      .set_rx (aim & cfg_txrx),
      .clr    (release_all),
      .tx_q   (tx_sd_flag[b]),
      .rx_q   (rx_sd_flag[b])
    );

    assign inh_bit[b] = tx_sd_flag[b] & ~cfg_pin_mode;
    assign inh_pin[b] = tx_sd_flag[b] &  cfg_pin_mode;
  end

  xsd_store_seq #(.DATA_W(DATA_W)) u_store (
    .clk        (clk),
    .rst_sn     (rst_sn),
    .soft_clr   (sw_reset),
    .accept     ((act == ACT_SHUT) & ~sw_reset),
    .no_status  (cmd_bcast | tx_blocked),
    .data_in    (cmd_data),
    .stat_done  (stat_done),
    .store_stb  (store_stb),
    .store_sel  (store_sel),
    .store_word (store_word)
  );

  always_comb begin
    send_d = 1'b0;
    irq_d  = 1'b0;
    me_d   = stat_me;
    bcr_d  = stat_bcr;
    if (sw_reset) begin
      me_d  = 1'b0;
      bcr_d = 1'b0;
    end else if (answer) begin
      send_d = ~cmd_bcast & ~tx_blocked;
      me_d   = (act == ACT_ILLEGAL);
      bcr_d  = cmd_bcast;
      irq_d  = (act == ACT_SHUT) & ~cfg_auto;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      rsp_send <= 1'b0;
      stat_me  <= 1'b0;
      stat_bcr <= 1'b0;
      irq      <= 1'b0;
    end else begin
      rsp_send <= send_d;
      stat_me  <= me_d;
      stat_bcr <= bcr_d;
      irq      <= irq_d;
    end
  end

  p_send_after_cmd_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    rsp_send |-> $past(cmd_stb));
  p_send_not_bcast_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    rsp_send |-> !stat_bcr);
  p_irq_no_shutdown_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    irq |-> $stable(tx_sd_flag));
  p_rx_shut_deaf_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    (cmd_stb && rx_sd_flag[cmd_bus] && !sw_reset) |=> (!rsp_send && $stable(stat_me)));
endmodule

// File: tb/test_xsd_shutdown_ctrl.sv
module test_xsd_shutdown_ctrl;
  localparam int DW = 4;
  localparam logic [DW-1:0] SEL_A = 4'd5;
  localparam logic [DW-1:0] SEL_B = 4'd10;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_stb, cmd_valid, cmd_mc, cmd_tr, cmd_bus, cmd_bcast;
  logic [4:0] cmd_code;
  logic [DW-1:0] cmd_data;
  logic stat_done, sw_reset;
  logic cfg_auto, cfg_txrx, cfg_undef_invalid, cfg_pin_mode;
  logic rsp_send, stat_me, stat_bcr, irq, store_stb, store_sel;
  logic [DW-1:0] store_word;
  logic [1:0] tx_sd_flag, rx_sd_flag, inh_bit, inh_pin;

  int checks = 0;
  int fails = 0;
  logic exp_sel = 1'b0;

  always #2 clk = ~clk;

  xsd_shutdown_ctrl #(.DATA_W(DW)) i_xsd_shutdown_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_stb(cmd_stb), .cmd_valid(cmd_valid), .cmd_mc(cmd_mc), .cmd_tr(cmd_tr),
    .cmd_bus(cmd_bus), .cmd_bcast(cmd_bcast), .cmd_code(cmd_code), .cmd_data(cmd_data),
    .sel_a(SEL_A), .sel_b(SEL_B), .stat_done(stat_done), .sw_reset(sw_reset),
    .cfg_auto(cfg_auto), .cfg_txrx(cfg_txrx), .cfg_undef_invalid(cfg_undef_invalid),
    .cfg_pin_mode(cfg_pin_mode),
    .rsp_send(rsp_send), .stat_me(stat_me), .stat_bcr(stat_bcr), .irq(irq),
    .store_stb(store_stb), .store_sel(store_sel), .store_word(store_word),
    .tx_sd_flag(tx_sd_flag), .rx_sd_flag(rx_sd_flag), .inh_bit(inh_bit), .inh_pin(inh_pin)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic issue(input logic bus, input logic tr, input logic [4:0] code,
                       input logic mc, input logic valid, input logic bc,
                       input logic [DW-1:0] data);
    @(negedge clk);
    cmd_stb = 1'b1; cmd_bus = bus; cmd_tr = tr; cmd_code = code;
    cmd_mc = mc; cmd_valid = valid; cmd_bcast = bc; cmd_data = data;
    @(negedge clk);
    cmd_stb = 1'b0; cmd_valid = 1'b0; cmd_mc = 1'b0; cmd_bcast = 1'b0;
    cmd_tr = 1'b0; cmd_code = '0; cmd_data = '0;
  endtask

  task automatic finish_status();
    stat_done = 1'b1;
    @(negedge clk);
    stat_done = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #700000;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    rst_n = 1'b0;
    cmd_stb = 0; cmd_valid = 0; cmd_mc = 0; cmd_tr = 0; cmd_bus = 0; cmd_bcast = 0;
    cmd_code = '0; cmd_data = '0; stat_done = 0; sw_reset = 0;
    cfg_auto = 0; cfg_txrx = 0; cfg_undef_invalid = 0; cfg_pin_mode = 0;
    repeat (3) tick();
    // R1 reset state
    check("R1 rsp_send", rsp_send, 0);
    check("R1 status", {stat_me, stat_bcr, irq}, 0);
    check("R1 store", {store_stb, store_sel, store_word}, 0);
    check("R1 flags", {tx_sd_flag, rx_sd_flag, inh_bit, inh_pin}, 0);
    rst_n = 1'b1;
    repeat (4) tick();

    // Exhaustive sweep: R2 R6 R7 R8 R9 R11
    for (int cfg = 0; cfg < 8; cfg++) begin
      for (int bus = 0; bus < 2; bus++) begin
        for (int d = 0; d < 16; d++) begin
          logic hit;
          logic [1:0] txe, rxe;
          cfg_auto = cfg[0]; cfg_txrx = cfg[1]; cfg_pin_mode = cfg[2];
          hit = cfg_auto && (d[DW-1:0] == (bus == 1 ? SEL_A : SEL_B));
          txe = hit ? (bus == 1 ? 2'b01 : 2'b10) : 2'b00;
          rxe = cfg_txrx ? txe : 2'b00;
          issue(bus[0], 1'b0, 5'd20, 1'b1, 1'b1, 1'b0, d[DW-1:0]);
          check("R2 rsp_send", rsp_send, 1);
          check("R2 me/bcr", {stat_me, stat_bcr}, 0);
          check("R8 irq", irq, !cfg_auto);
          check("R6 tx flag", tx_sd_flag, txe);
          check("R6 rx flag", rx_sd_flag, rxe);
          check("R7 inh_pin", inh_pin, cfg_pin_mode ? txe : 2'b00);
          check("R7 inh_bit", inh_bit, cfg_pin_mode ? 2'b00 : txe);
          check("R9 no early store", store_stb, 0);
          finish_status();
          exp_sel = ~exp_sel;
          check("R9 store_stb", store_stb, 1);
          check("R9 store_sel", store_sel, exp_sel);
          check("R9 store_word", store_word, d);
          if (hit) begin
            issue(bus[0], 1'b1, 5'd8, 1'b1, 1'b1, 1'b0, '0);
            check("R11 code 8 release", {tx_sd_flag, rx_sd_flag, inh_bit, inh_pin}, 0);
          end
        end
      end
    end

    // R3 broadcast
    cfg_auto = 1; cfg_txrx = 0; cfg_pin_mode = 0;
    issue(1'b0, 1'b0, 5'd20, 1'b1, 1'b1, 1'b1, 4'd3);
    check("R3 bcr set", stat_bcr, 1);
    check("R3 me clear", stat_me, 0);
    check("R3 no status", rsp_send, 0);
    tick();
    exp_sel = ~exp_sel;
    check("R9 bcast store", store_stb, 1);
    check("R9 bcast sel", store_sel, exp_sel);
    check("R9 bcast word", store_word, 3);

    // R5 illegal treatment
    cfg_undef_invalid = 1;
    issue(1'b0, 1'b1, 5'd20, 1'b1, 1'b1, 1'b0, SEL_B);
    check("R5 me set", stat_me, 1);
    check("R5 bcr clear", stat_bcr, 0);
    check("R5 status sent", rsp_send, 1);
    check("R5 no shutdown", tx_sd_flag, 0);
    finish_status();
    check("R5 no store", store_stb, 0);
    issue(1'b1, 1'b1, 5'd20, 1'b1, 1'b1, 1'b1, '0);
    check("R5 bcast me", stat_me, 1);
    check("R5 bcast bcr", stat_bcr, 1);
    check("R5 bcast silent", rsp_send, 0);

    // R4 ignore undefined direction
    cfg_undef_invalid = 0;
    issue(1'b0, 1'b0, 5'd20, 1'b1, 1'b1, 1'b0, 4'd0);
    finish_status();
    exp_sel = ~exp_sel;
    check("R4 setup me", stat_me, 0);
    issue(1'b0, 1'b1, 5'd20, 1'b1, 1'b1, 1'b1, SEL_B);
    check("R4 me kept", stat_me, 0);
    check("R4 bcr kept", stat_bcr, 0);
    check("R4 no response", {rsp_send, irq}, 0);
    check("R4 no shutdown", tx_sd_flag, 0);
    tick();
    check("R4 no store", store_stb, 0);
    check("R4 sel kept", store_sel, exp_sel);

    // R12 invalid word
    issue(1'b0, 1'b0, 5'd20, 1'b1, 1'b0, 1'b0, SEL_B);
    check("R12 no response", {rsp_send, irq, stat_me, stat_bcr}, 0);
    check("R12 no shutdown", tx_sd_flag, 0);
    tick();
    check("R12 no store", store_stb, 0);

    // R10 transmit-blocked bus
    cfg_auto = 1; cfg_txrx = 0;
    issue(1'b0, 1'b0, 5'd20, 1'b1, 1'b1, 1'b0, SEL_B);
    finish_status();
    exp_sel = ~exp_sel;
    check("R10 setup tx B", {tx_sd_flag, rx_sd_flag}, 4'b1000);
    issue(1'b1, 1'b0, 5'd20, 1'b1, 1'b1, 1'b0, 4'd0);
    check("R10 tx blocked silent", rsp_send, 0);
    check("R10 obeyed me", stat_me, 0);
    tick();
    exp_sel = ~exp_sel;
    check("R10 store w/o status", store_stb, 1);
    check("R10 store sel", store_sel, exp_sel);
    issue(1'b0, 1'b1, 5'd17, 1'b1, 1'b1, 1'b0, '0);
    check("R11 code 17 keeps", tx_sd_flag, 2'b10);
    issue(1'b0, 1'b1, 5'd5, 1'b1, 1'b1, 1'b0, '0);
    check("R11 code 5 release", tx_sd_flag, 0);

    // R10 receive-blocked bus
    cfg_txrx = 1;
    issue(1'b0, 1'b0, 5'd20, 1'b1, 1'b1, 1'b0, SEL_B);
    finish_status();
    exp_sel = ~exp_sel;
    check("R10 setup rx B", {tx_sd_flag, rx_sd_flag}, 4'b1010);
    issue(1'b1, 1'b0, 5'd20, 1'b1, 1'b1, 1'b1, SEL_A);
    check("R10 rx blocked ignored", {rsp_send, stat_bcr}, 0);
    check("R10 no cross shutdown", tx_sd_flag, 2'b10);
    tick();
    check("R10 no store", store_stb, 0);
    issue(1'b0, 1'b0, 5'd21, 1'b1, 1'b1, 1'b0, '0);
    check("R11 code 21 release", {tx_sd_flag, rx_sd_flag}, 0);

    // R11 software reset
    issue(1'b1, 1'b0, 5'd20, 1'b1, 1'b1, 1'b0, SEL_A);
    check("R6 shut A", {tx_sd_flag, rx_sd_flag}, 4'b0101);
    sw_reset = 1'b1;
    tick();
    sw_reset = 1'b0;
    check("R11 sw reset", {tx_sd_flag, rx_sd_flag}, 0);

    // R1 hardware reset
    issue(1'b1, 1'b0, 5'd20, 1'b1, 1'b1, 1'b0, SEL_A);
    check("R6 shut A again", tx_sd_flag, 2'b01);
    rst_n = 1'b0;
    #1;
    check("R1 hw reset flags", {tx_sd_flag, rx_sd_flag, inh_bit, inh_pin}, 0);
    check("R1 hw reset store", {store_stb, store_sel}, 0);
    tick();
    rst_n = 1'b1;
    repeat (4) tick();

    summary();
  end
endmodule